// File: doc/BRIEF.md
# Table-Driven Sweep DAC Sequencer

This block walks a pair of serial sweep DACs through a voltage pattern stored in an internal table RAM. The table is filled word by word through a register-side write port. Once a sweep is enabled, the controller first waits for a one-second tick to align itself. After that, each rising edge of the accumulation-interval input fetches the next pattern word for every sweep DAC and shifts it out serially. A full sweep has 32 steps. At 128 interval edges per second this gives four sweeps per second.

Independently of the sweep, each one-second tick reloads two fixed DACs. One fixed DAC sets the detector bias and the other sets the test pulser. Their values come from register inputs. All four DACs share one serial format, with a clock, load, clear and data line per DAC. The table cannot be written while the sweep is enabled or the controller is still running. If an interval edge arrives while a table read or DAC shift is still in progress, the edge is reported as an overrun and dropped.

Top module: `sweep_dac_seq`

## Requirements
- R1: While `rst_n` is low, every serial clock, load and data line and `overrun` are 0, every clear line is 1, and `step_idx` is 0. The clear lines fall to 0 on the first clock edge after reset is released.
- R2: Each DAC word is 16 bits, sent MSB first. Each bit is valid at a rising edge of that DAC's serial clock, and a serial clock period is two system clocks. After the last bit, load goes high while the serial clock is low and stays high for one full serial clock period. No data bit is clocked while load is high.
- R3: After `sweep_en` rises, interval edges are ignored and produce no DAC traffic until a `sec_tick` pulse has been seen.
- R4: Once aligned, each rising edge of `accum_tick` loads sweep DAC k with the table word at address {k, step}. Bit 5 of the address is the DAC select and bits 4:0 are the step index.
- R5: `step_idx` advances by one after both sweep DAC loads of a step have finished, and it wraps from 31 to 0.
- R6: Every `sec_tick` loads fixed DAC 0 with `bias_val` and fixed DAC 1 with `pulser_val`, whether or not a sweep is running.
- R7: A table write is ignored while `sweep_en` is high or the controller has not yet returned to idle. A write made while idle takes effect.
- R8: A rising edge of `accum_tick` that arrives while a step is being read or shifted raises `overrun` for one cycle, on the next clock. That edge starts no DAC traffic and does not advance the step.
- R9: When `sweep_en` is low, the controller returns to idle and `step_idx` is 0 on the next clock. Interval edges then cause no sweep traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sweep_en | input | 1 | Enables the sweep; low forces the controller back to idle |
| accum_tick | input | 1 | Accumulation-interval signal; its rising edge requests a step |
| sec_tick | input | 1 | One-second pulse: aligns the sweep and reloads the fixed DACs |
| tbl_wr | input | 1 | Table write strobe |
| tbl_waddr | input | 8 | Table write address (word) |
| tbl_wdata | input | 16 | Table write data |
| bias_val | input | 16 | Value for fixed DAC 0 |
| pulser_val | input | 16 | Value for fixed DAC 1 |
| sdac_sck | output | 2 | Sweep DAC serial clocks |
| sdac_ld | output | 2 | Sweep DAC load strobes |
| sdac_clr | output | 2 | Sweep DAC clear lines |
| sdac_dat | output | 2 | Sweep DAC serial data |
| fdac_sck | output | 2 | Fixed DAC serial clocks |
| fdac_ld | output | 2 | Fixed DAC load strobes |
| fdac_clr | output | 2 | Fixed DAC clear lines |
| fdac_dat | output | 2 | Fixed DAC serial data |
| overrun | output | 1 | One-cycle pulse for a dropped interval edge |
| step_idx | output | 5 | Current sweep step index |

## Verification
The assertions check the shape of the load strobe relative to the serial clock on every cycle. They also check that the step index only moves by +1 or back to 0, that it is held at 0 whenever the sweep is disabled, and that every overrun pulse follows a fresh interval edge while the sweep is enabled. The bench's scenarios are needed for everything else. They show that the right table words reach the right DAC, that the wait for alignment works, that the table is write-protected during a sweep, that the step index wraps after a full sweep, that a dropped edge leaves the pattern intact, and that the fixed DACs are reloaded with the register values. They do this by rebuilding every serial word and comparing it against a queue of expected words.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SYNC,
      ST_ARMED,
      ST_READ,
      ST_LOAD,
      ST_DONE
   } seq_state_t;
endpackage

// File: rtl/sweep_lut.sv
module sweep_lut #(
   parameter int DW     = 16,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DW-1:0]     wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DW-1:0]     rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/dac_ser.sv
module dac_ser #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] word,
   output logic         busy,
   output logic         sck,
   output logic         ld,
   output logic         clr,
   output logic         dat
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  sh;
   logic [CW-1:0] cnt;
   logic          ph;
   logic          ldph;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh   <= '0;
         cnt  <= '0;
         ph   <= 1'b0;
         ldph <= 1'b0;
         busy <= 1'b0;
         sck  <= 1'b0;
         ld   <= 1'b0;
         clr  <= 1'b1;
      end else begin
         clr <= 1'b0;
         if (!busy) begin
            if (start) begin
               sh   <= word;
               busy <= 1'b1;
               cnt  <= '0;
               ph   <= 1'b0;
               ldph <= 1'b0;
               sck  <= 1'b0;
            end
         end else if (!ph) begin
            sck <= 1'b1;
            ph  <= 1'b1;
         end else begin
            sck <= 1'b0;
            ph  <= 1'b0;
            if (ldph) begin
               ld   <= 1'b0;
               ldph <= 1'b0;
               busy <= 1'b0;
            end else if (cnt == CW'(W - 1)) begin
               ldph <= 1'b1;
               ld   <= 1'b1;
               sh   <= sh << 1;
            end else begin
               sh  <= sh << 1;
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign dat = busy & ~ldph & sh[W-1];
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
   import sweep_pkg::*;
#(
   parameter int DW     = 16,
   parameter int ADDR_W = 8,
   parameter int STEPS  = 32,
   parameter int NS     = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sweep_en,
   input  logic                       accum_tick,
   input  logic                       sec_tick,
   input  logic [DW-1:0]              rdata,
   input  logic [NS-1:0]              sh_busy,
   output logic [ADDR_W-1:0]          raddr,
   output logic [NS-1:0]              sh_start,
   output logic                       active,
   output logic                       overrun,
   output logic [$clog2(STEPS)-1:0]   step_idx
);
   localparam int STEP_W = $clog2(STEPS);
   localparam int SEL_W  = (NS > 1) ? $clog2(NS) : 1;

   seq_state_t        st;
   logic [SEL_W-1:0]  sel;
   logic [SEL_W-1:0]  rsel_q;
   logic              rv_q;
   logic              acc_q;
   logic              rise;
   logic              in_step;

   assign rise    = accum_tick & ~acc_q;
   assign in_step = (st == ST_READ) || (st == ST_LOAD) || (st == ST_DONE);
   assign active  = sweep_en || (st != ST_IDLE);
   assign raddr   = ADDR_W'({sel, step_idx});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         sel      <= '0;
         rsel_q   <= '0;
         rv_q     <= 1'b0;
         acc_q    <= 1'b0;
         overrun  <= 1'b0;
         step_idx <= '0;
      end else begin
         acc_q   <= accum_tick;
         overrun <= rise && in_step && sweep_en;
         rv_q    <= (st == ST_READ) && sweep_en;
         rsel_q  <= sel;
         if (!sweep_en) begin
            st       <= ST_IDLE;
            sel      <= '0;
            step_idx <= '0;
         end else begin
            unique case (st)
               ST_IDLE:  st <= ST_SYNC;
               ST_SYNC:  if (sec_tick) st <= ST_ARMED;
               ST_ARMED: if (rise) begin
                  st  <= ST_READ;
                  sel <= '0;
               end
               ST_READ:  if (sel == SEL_W'(NS - 1)) st <= ST_LOAD;
                         else sel <= sel + 1'b1;
               ST_LOAD:  st <= ST_DONE;
               ST_DONE:  if (sh_busy == '0) begin
                  st  <= ST_ARMED;
                  sel <= '0;
                  step_idx <= (step_idx == STEP_W'(STEPS - 1)) ? '0 : step_idx + 1'b1;
               end
               default:  st <= ST_IDLE;
            endcase
         end
      end
   end

   for (genvar k = 0; k < NS; k++) begin : g_start
      assign sh_start[k] = rv_q && (rsel_q == SEL_W'(k));
   end

   logic unused_rdata;
   assign unused_rdata = ^rdata;
endmodule

// File: rtl/sweep_dac_seq.sv
module sweep_dac_seq #(
   parameter int DW     = 16,
   parameter int ADDR_W = 8,
   parameter int STEPS  = 32,
   parameter int NS     = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      sweep_en,
   input  logic                      accum_tick,
   input  logic                      sec_tick,
   input  logic                      tbl_wr,
   input  logic [ADDR_W-1:0]         tbl_waddr,
   input  logic [DW-1:0]             tbl_wdata,
   input  logic [DW-1:0]             bias_val,
   input  logic [DW-1:0]             pulser_val,
   output logic [NS-1:0]             sdac_sck,
   output logic [NS-1:0]             sdac_ld,
   output logic [NS-1:0]             sdac_clr,
   output logic [NS-1:0]             sdac_dat,
   output logic [1:0]                fdac_sck,
   output logic [1:0]                fdac_ld,
   output logic [1:0]                fdac_clr,
   output logic [1:0]                fdac_dat,
   output logic                      overrun,
   output logic [$clog2(STEPS)-1:0]  step_idx
);
   localparam int STEP_W = $clog2(STEPS);
   localparam int SEL_W  = (NS > 1) ? $clog2(NS) : 1;

   if (ADDR_W < SEL_W + STEP_W) begin : g_bad_addr
      $error("sweep_dac_seq: ADDR_W too small for select plus step");
   end
   if (STEPS < 2 || NS < 1 || DW < 2) begin : g_bad_cfg
      $error("sweep_dac_seq: invalid STEPS, NS or DW");
   end

   logic [ADDR_W-1:0] raddr;
   logic [DW-1:0]     rdata;
   logic [NS-1:0]     sh_start;
   logic [NS-1:0]     sh_busy;
   logic [1:0]        f_busy;
   logic              active;
   logic [DW-1:0]     fword [2];

   assign fword[0] = bias_val;
   assign fword[1] = pulser_val;

   sweep_lut #(.DW(DW), .ADDR_W(ADDR_W)) u_lut (
      .clk   (clk),
      .we    (tbl_wr & ~active),
      .waddr (tbl_waddr),
      .wdata (tbl_wdata),
      .raddr (raddr),
      .rdata (rdata)
   );

   sweep_ctrl #(.DW(DW), .ADDR_W(ADDR_W), .STEPS(STEPS), .NS(NS)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .sweep_en   (sweep_en),
      .accum_tick (accum_tick),
      .sec_tick   (sec_tick),
      .rdata      (rdata),
      .sh_busy    (sh_busy),
      .raddr      (raddr),
      .sh_start   (sh_start),
      .active     (active),
      .overrun    (overrun),
      .step_idx   (step_idx)
   );

   for (genvar k = 0; k < NS; k++) begin : g_sweep
      dac_ser #(.W(DW)) u_ser (
         .clk   (clk),
         .rst_n (rst_n),
         .start (sh_start[k]),
         .word  (rdata),
         .busy  (sh_busy[k]),
         .sck   (sdac_sck[k]),
         .ld    (sdac_ld[k]),
         .clr   (sdac_clr[k]),
         .dat   (sdac_dat[k])
      );
   end

   for (genvar k = 0; k < 2; k++) begin : g_fixed
      dac_ser #(.W(DW)) u_ser (
         .clk   (clk),
         .rst_n (rst_n),
         .start (sec_tick),
         .word  (fword[k]),
         .busy  (f_busy[k]),
         .sck   (fdac_sck[k]),
         .ld    (fdac_ld[k]),
         .clr   (fdac_clr[k]),
         .dat   (fdac_dat[k])
      );
   end

   logic unused_fbusy;
   assign unused_fbusy = ^f_busy;
endmodule

// File: rtl/sweep_dac_seq_chk.sv
module sweep_dac_seq_chk #(
   parameter int STEPS = 32,
   parameter int NS    = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      sweep_en,
   input logic                      accum_tick,
   input logic [NS-1:0]             sdac_sck,
   input logic [NS-1:0]             sdac_ld,
   input logic [1:0]                fdac_sck,
   input logic [1:0]                fdac_ld,
   input logic                      overrun,
   input logic [$clog2(STEPS)-1:0]  step_idx
);
   AST_STEP_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_idx != $past(step_idx)) |-> (step_idx == '0 || step_idx == $past(step_idx) + 1'b1)); // R5

   AST_STEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sweep_en) |-> (step_idx == '0)); // R9

   AST_OVR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> ($past(accum_tick) && !$past(accum_tick, 2))); // R8

   AST_OVR_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(sweep_en)); // R8

   for (genvar k = 0; k < NS; k++) begin : g_sw
      AST_SLD_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sdac_ld[k]) |-> !sdac_sck[k]); // R2
      AST_SLD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sdac_ld[k]) |=> (sdac_ld[k] && sdac_sck[k])); // R2
   end

   for (genvar k = 0; k < 2; k++) begin : g_fx
      AST_FLD_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(fdac_ld[k]) |-> !fdac_sck[k]); // R2
      AST_FLD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(fdac_ld[k]) |=> (fdac_ld[k] && fdac_sck[k])); // R2
   end
endmodule

bind sweep_dac_seq sweep_dac_seq_chk #(.STEPS(STEPS), .NS(NS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sweep_en   (sweep_en),
   .accum_tick (accum_tick),
   .sdac_sck   (sdac_sck),
   .sdac_ld    (sdac_ld),
   .fdac_sck   (fdac_sck),
   .fdac_ld    (fdac_ld),
   .overrun    (overrun),
   .step_idx   (step_idx)
);

// File: tb/sweep_dac_seq_tb_top.sv
module sweep_dac_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sweep_en = 1'b0;
   logic        accum_tick = 1'b0;
   logic        sec_tick = 1'b0;
   logic        tbl_wr = 1'b0;
   logic [7:0]  tbl_waddr = '0;
   logic [15:0] tbl_wdata = '0;
   logic [15:0] bias_val = '0;
   logic [15:0] pulser_val = '0;
   logic [1:0]  sdac_sck, sdac_ld, sdac_clr, sdac_dat;
   logic [1:0]  fdac_sck, fdac_ld, fdac_clr, fdac_dat;
   logic        overrun;
   logic [4:0]  step_idx;

   int checks = 0;
   int failures = 0;
   int ovr_cnt = 0;
   bit done = 0;
   string sw_tag = "R4";

   logic [15:0] expq [4][$];
   int          nbits [4];
   logic [15:0] acc [4];
   logic [3:0]  prev_sck = '0;
   logic [3:0]  prev_ld = '0;

   always #4 clk = ~clk;

   sweep_dac_seq dut_i (
      .clk(clk), .rst_n(rst_n), .sweep_en(sweep_en), .accum_tick(accum_tick),
      .sec_tick(sec_tick), .tbl_wr(tbl_wr), .tbl_waddr(tbl_waddr),
      .tbl_wdata(tbl_wdata), .bias_val(bias_val), .pulser_val(pulser_val),
      .sdac_sck(sdac_sck), .sdac_ld(sdac_ld), .sdac_clr(sdac_clr), .sdac_dat(sdac_dat),
      .fdac_sck(fdac_sck), .fdac_ld(fdac_ld), .fdac_clr(fdac_clr), .fdac_dat(fdac_dat),
      .overrun(overrun), .step_idx(step_idx)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
      end
   endtask

   function automatic logic [15:0] tv(input int s, input int st);
      return {(s != 0) ? 8'hC3 : 8'h5A, 3'b101, 5'(st)};
   endfunction

   // Per-clock serial reconstruction and comparison against the model queues
   always @(negedge clk) begin
      logic [3:0] sck4, ld4, dat4;
      sck4 = {fdac_sck, sdac_sck};
      ld4  = {fdac_ld, sdac_ld};
      dat4 = {fdac_dat, sdac_dat};
      if (rst_n) begin
         if (overrun) ovr_cnt++;
         for (int c = 0; c < 4; c++) begin
            if (sck4[c] && !prev_sck[c] && !ld4[c]) begin
               acc[c] = {acc[c][14:0], dat4[c]};
               nbits[c]++;
            end
            if (!ld4[c] && prev_ld[c]) begin
               chk(nbits[c] == 16, "R2 bit count", nbits[c], 16);
               if (expq[c].size() == 0) begin
                  chk(1'b0, (c < 2) ? sw_tag : "R6", int'(acc[c]), 0);
               end else begin
                  logic [15:0] e;
                  e = expq[c].pop_front();
                  chk(acc[c] == e, (c < 2) ? sw_tag : "R6", int'(acc[c]), int'(e));
               end
               nbits[c] = 0;
            end
         end
      end else begin
         for (int c = 0; c < 4; c++) nbits[c] = 0;
      end
      prev_sck = sck4;
      prev_ld  = ld4;
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic tick();
      @(posedge clk); #1 accum_tick = 1'b1;
      @(posedge clk); @(posedge clk); #1 accum_tick = 1'b0;
   endtask

   task automatic pulse_sec();
      @(posedge clk); #1 sec_tick = 1'b1;
      @(posedge clk); #1 sec_tick = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(posedge clk); #1 tbl_wr = 1'b1; tbl_waddr = a; tbl_wdata = d;
      @(posedge clk); #1 tbl_wr = 1'b0;
   endtask

   task automatic queues_empty(input string tag);
      for (int c = 0; c < 4; c++) chk(expq[c].size() == 0, tag, expq[c].size(), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 4; c++) begin nbits[c] = 0; acc[c] = '0; end
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk(sdac_clr == 2'b11 && fdac_clr == 2'b11, "R1 clr", {sdac_clr, fdac_clr}, 4'hF);
      chk(sdac_sck == 0 && sdac_ld == 0 && sdac_dat == 0 && fdac_sck == 0 && fdac_ld == 0
          && fdac_dat == 0, "R1 lines", {sdac_sck, sdac_ld, sdac_dat}, 0);
      chk(overrun == 1'b0 && step_idx == 0, "R1 ovr/step", {overrun, step_idx}, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      wait_cyc(1);
      chk(sdac_clr == 0 && fdac_clr == 0, "R1 clr release", {sdac_clr, fdac_clr}, 0);

      // Fill table while idle
      for (int s = 0; s < 2; s++)
         for (int st = 0; st < 32; st++)
            wr(8'({s[0], 5'(st)}), tv(s, st));

      // R6 fixed DAC reload with sweep off
      bias_val = 16'h1234; pulser_val = 16'hBEEF;
      expq[2].push_back(16'h1234); expq[3].push_back(16'hBEEF);
      pulse_sec();
      wait_cyc(50);
      queues_empty("R6");

      // R3 edges before alignment are ignored
      sweep_en = 1'b1;
      wait_cyc(3);
      tick();
      wait_cyc(60);
      chk(step_idx == 0, "R3 step", step_idx, 0);
      queues_empty("R3");

      // R7 write attempt during sweep
      wr({1'b0, 1'b0, 1'b0, 5'd1}, 16'h0BAD);

      bias_val = 16'h0F0F;
      expq[2].push_back(16'h0F0F); expq[3].push_back(16'hBEEF);
      pulse_sec();
      wait_cyc(50);
      queues_empty("R6 during sweep");

      // R4/R5 full sweep plus wrap
      for (int n = 0; n < 34; n++) begin
         sw_tag = (n == 1) ? "R7 protected" : "R4";
         expq[0].push_back(tv(0, n % 32));
         expq[1].push_back(tv(1, n % 32));
         tick();
         wait_cyc(80);
         chk(int'(step_idx) == (n + 1) % 32, "R5 step", step_idx, (n + 1) % 32);
      end
      sw_tag = "R4";
      queues_empty("R4");

      // R8 overrun
      expq[0].push_back(tv(0, 2)); expq[1].push_back(tv(1, 2));
      tick();
      wait_cyc(4);
      tick();
      wait_cyc(80);
      chk(ovr_cnt == 1, "R8 overrun count", ovr_cnt, 1);
      chk(step_idx == 3, "R8 step", step_idx, 3);
      queues_empty("R8");

      // R9 disable
      sweep_en = 1'b0;
      wait_cyc(2);
      chk(step_idx == 0, "R9 step reset", step_idx, 0);
      tick();
      wait_cyc(60);
      chk(step_idx == 0, "R9 idle step", step_idx, 0);
      chk(ovr_cnt == 1, "R9 no overrun", ovr_cnt, 1);

      // R7 write while idle takes effect
      wr(8'h00, 16'h7777);
      sweep_en = 1'b1;
      expq[2].push_back(16'h0F0F); expq[3].push_back(16'hBEEF);
      pulse_sec();
      wait_cyc(50);
      sw_tag = "R7 idle write";
      expq[0].push_back(16'h7777); expq[1].push_back(tv(1, 0));
      tick();
      wait_cyc(80);
      queues_empty("R7");
      chk(step_idx == 1, "R5 step after reenable", step_idx, 1);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule